// File: doc/BRIEF.md
# Four-Way Page Translation Buffer

This block caches translations from 4 KB virtual pages to physical page frames. It holds 64 entries arranged as 16 sets of four ways. A lookup presents a 32-bit virtual address. One cycle later the block reports whether the translation hit, gives the 32-bit physical address, and raises an error flag if the matching entry failed its parity check. The low 12 address bits are the page offset and are passed through unchanged. The upper 20 bits are replaced by the stored frame number.

New translations arrive on a separate fill port, typically from a page walker that runs outside this block. The fill port writes either the way that already holds the same page, the first empty way of the set, or the way named by a 3-bit tree pseudo-LRU kept for each set. A single flush input empties the whole buffer.

Every stored tag and every stored frame number carries an even parity bit, written at fill time. A test input can invert either bit during a fill, so that the checking path can be exercised through the ports.

Top module: `xlat_tlb`

## Requirements
- R1: A lookup presented on a clock edge produces its result on `lk_hit`, `lk_perr` and `lk_paddr` after that edge. A cycle without `lk_valid` gives `lk_hit`=0, `lk_perr`=0 and `lk_paddr`=0 in the following cycle.
- R2: On a hit, `lk_paddr` equals the stored 20-bit frame number in bits [31:12], followed by the lookup's virtual bits [11:0]. On a miss or a parity error, `lk_paddr` is 0.
- R3: The set is virtual bits [15:12] and the tag is bits [31:16]. A hit requires a valid entry in that set whose stored tag equals the tag. A fill takes a 20-bit page number whose low 4 bits are the set.
- R4: A fill whose tag already sits in a valid way of its set overwrites that way. Otherwise the fill goes to the lowest-numbered invalid way, if there is one.
- R5: When all four ways hold other tags, the victim comes from the set's pseudo-LRU bits. If bit0=0, the victim is way 0 or way 1, chosen by bit1 (0 gives way 0). If bit0=1, the victim is way 2 or way 3, chosen by bit2 (0 gives way 2).
- R6: A parity-clean hit or any fill to way w sets bit0 to 1 if w<2, and to 0 otherwise. It also sets bit1 (for w<2) or bit2 (for w>=2) to the inverse of w's low bit. Misses and parity-error lookups leave the bits unchanged. When a lookup and a fill touch the same set in one cycle, the lookup update is applied first and then the fill update.
- R7: Reset and `flush` clear every valid flag and every pseudo-LRU state to zero. A fill in the same cycle as `flush` is discarded.
- R8: A fill stores even parity of the 16-bit tag and of the 20-bit frame. `fill_par_flip` bit 0 inverts the stored tag parity bit, and bit 1 inverts the stored frame parity bit.
- R9: A lookup whose tag matches a valid entry with a bad tag or frame parity bit reports `lk_hit`=0 and `lk_perr`=1.
- R10: A lookup in the same cycle as a fill or a flush sees the buffer contents from before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries and clear replacement state |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Registered hit result |
| lk_paddr | output | 32 | Registered physical address (0 unless hit) |
| lk_perr | output | 1 | Registered parity error on the matching entry |
| fill_valid | input | 1 | Write a translation this cycle |
| fill_vpn | input | 20 | Virtual page number of the new translation |
| fill_pfn | input | 20 | Physical frame number of the new translation |
| fill_par_flip | input | 2 | Error injection: bit 0 inverts tag parity, bit 1 inverts frame parity |

## Verification
The hardest state to reach from the ports is a full set whose pseudo-LRU bits have been moved by a particular mix of hits and fills. Only then does a fifth fill reveal the victim choice. The bench sweeps all 16 sets. In each set it fills six tags and performs hits in a different, set-dependent order between the fills. It then probes every tag, comparing each result against a reference model that is rebuilt arithmetically from the bit rules. Parity faults are planted through the flip input. Same-edge fill and lookup collisions are forced with directed cycles.

// File: rtl/xlat_tlb_pkg.sv
package xlat_tlb_pkg;

  // Associativity is fixed at four by the 3-bit tree replacement state.
  localparam int unsigned WAYS = 4;

  typedef logic [1:0] way_t;
  typedef logic [2:0] plru_t;

  // Victim: bit0 picks the pair, bit1/bit2 pick within pair 0/1.
  function automatic way_t plru_victim(input plru_t st);
    way_t w;
    if (st[0]) w = {1'b1, st[2]};
    else       w = {1'b0, st[1]};
    return w;
  endfunction

  // Move the tree away from way w.
  function automatic plru_t plru_touch(input plru_t st, input way_t w);
    plru_t r;
    r    = st;
    r[0] = ~w[1];
    if (w[1]) r[2] = ~w[0];
    else      r[1] = ~w[0];
    return r;
  endfunction

  // Index of the set bit in a one-hot (or zero) vector.
  function automatic way_t onehot_idx(input logic [WAYS-1:0] v);
    way_t r;
    r = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (v[i]) r = way_t'(i);
    end
    return r;
  endfunction

  // Lowest-numbered clear bit.
  function automatic way_t first_clear(input logic [WAYS-1:0] v);
    way_t r;
    r = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!v[i]) r = way_t'(i);
    end
    return r;
  endfunction

  // Even parity bit over up to 32 bits (zero-extended).
  function automatic logic even_par(input logic [31:0] v);
    return ^v;
  endfunction

endpackage

// File: rtl/xlat_tlb_store.sv
module xlat_tlb_store
  import xlat_tlb_pkg::*;
#(
  parameter int unsigned SETS  = 16,
  parameter int unsigned TAG_W = 16,
  parameter int unsigned PFN_W = 20,
  localparam int unsigned IDX_W = $clog2(SETS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        flush,
  // write port
  input  logic                        we,
  input  logic [IDX_W-1:0]            wr_set,
  input  way_t                        wr_way,
  input  logic [TAG_W-1:0]            wr_tag,
  input  logic [PFN_W-1:0]            wr_pfn,
  input  logic                        wr_tpar,
  input  logic                        wr_dpar,
  // read port A (lookup)
  input  logic [IDX_W-1:0]            ra_set,
  output logic [WAYS-1:0]             ra_vld,
  output logic [WAYS-1:0][TAG_W-1:0]  ra_tag,
  output logic [WAYS-1:0][PFN_W-1:0]  ra_pfn,
  output logic [WAYS-1:0]             ra_tpar,
  output logic [WAYS-1:0]             ra_dpar,
  // read port B (fill placement)
  input  logic [IDX_W-1:0]            rb_set,
  output logic [WAYS-1:0]             rb_vld,
  output logic [WAYS-1:0][TAG_W-1:0]  rb_tag
);

  logic [WAYS-1:0]  vld_m  [SETS];
  logic [TAG_W-1:0] tag_m  [SETS][WAYS];
  logic [PFN_W-1:0] pfn_m  [SETS][WAYS];
  logic             tpar_m [SETS][WAYS];
  logic             dpar_m [SETS][WAYS];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      for (int s = 0; s < SETS; s++) vld_m[s] <= '0;
    end else if (we) begin
      vld_m[wr_set][wr_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (we && !flush) begin
      tag_m[wr_set][wr_way]  <= wr_tag;
      pfn_m[wr_set][wr_way]  <= wr_pfn;
      tpar_m[wr_set][wr_way] <= wr_tpar;
      dpar_m[wr_set][wr_way] <= wr_dpar;
    end
  end

  assign ra_vld = vld_m[ra_set];
  assign rb_vld = vld_m[rb_set];

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign ra_tag[w]  = tag_m[ra_set][w];
    assign ra_pfn[w]  = pfn_m[ra_set][w];
    assign ra_tpar[w] = tpar_m[ra_set][w];
    assign ra_dpar[w] = dpar_m[ra_set][w];
    assign rb_tag[w]  = tag_m[rb_set][w];
  end

endmodule

// File: rtl/xlat_tlb_match.sv
module xlat_tlb_match
  import xlat_tlb_pkg::*;
#(
  parameter int unsigned TAG_W = 16,
  parameter int unsigned PFN_W = 20
) (
  input  logic [TAG_W-1:0]            cmp_tag,
  input  logic [WAYS-1:0]             vld,
  input  logic [WAYS-1:0][TAG_W-1:0]  tag,
  input  logic [WAYS-1:0][PFN_W-1:0]  pfn,
  input  logic [WAYS-1:0]             tpar,
  input  logic [WAYS-1:0]             dpar,
  output logic [WAYS-1:0]             good_vec,
  output logic [WAYS-1:0]             perr_vec,
  output logic [PFN_W-1:0]            hit_pfn
);

  logic [WAYS-1:0] raw_vec;
  logic [WAYS-1:0] bad_vec;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign raw_vec[w]  = vld[w] && (tag[w] == cmp_tag);
    assign bad_vec[w]  = (tpar[w] != even_par(32'(tag[w]))) ||
                         (dpar[w] != even_par(32'(pfn[w])));
    assign good_vec[w] = raw_vec[w] && !bad_vec[w];
    assign perr_vec[w] = raw_vec[w] && bad_vec[w];
  end

  always_comb begin
    hit_pfn = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (good_vec[w]) hit_pfn = hit_pfn | pfn[w];
    end
  end

endmodule

// File: rtl/xlat_tlb_plru.sv
module xlat_tlb_plru
  import xlat_tlb_pkg::*;
#(
  parameter int unsigned SETS = 16,
  localparam int unsigned IDX_W = $clog2(SETS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic                 lk_touch,
  input  logic [IDX_W-1:0]     lk_set,
  input  way_t                 lk_way,
  input  logic                 fl_touch,
  input  logic [IDX_W-1:0]     fl_set,
  input  way_t                 fl_way,
  output plru_t                fl_state,
  output logic [SETS*3-1:0]    all_state
);

  plru_t st_q [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    plru_t nxt;
    always_comb begin
      nxt = st_q[s];
      if (lk_touch && lk_set == IDX_W'(s)) nxt = plru_touch(nxt, lk_way);
      if (fl_touch && fl_set == IDX_W'(s)) nxt = plru_touch(nxt, fl_way);
    end
    always_ff @(posedge clk) begin
      if (!rst_n || flush) st_q[s] <= '0;
      else                 st_q[s] <= nxt;
    end
    assign all_state[s*3 +: 3] = st_q[s];
  end

  assign fl_state = st_q[fl_set];

endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import xlat_tlb_pkg::*;
#(
  parameter int unsigned VA_W   = 32,
  parameter int unsigned PA_W   = 32,
  parameter int unsigned PAGE_W = 12,
  parameter int unsigned SETS   = 16,
  localparam int unsigned IDX_W = $clog2(SETS),
  localparam int unsigned VPN_W = VA_W - PAGE_W,
  localparam int unsigned PFN_W = PA_W - PAGE_W,
  localparam int unsigned TAG_W = VPN_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_vaddr,
  output logic              lk_hit,
  output logic [PA_W-1:0]   lk_paddr,
  output logic              lk_perr,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic [1:0]        fill_par_flip
);

  // address split
  logic [IDX_W-1:0] lk_set, fl_set;
  logic [TAG_W-1:0] lk_tag, fl_tag;
  assign lk_set = lk_vaddr[PAGE_W +: IDX_W];
  assign lk_tag = lk_vaddr[VA_W-1 -: TAG_W];
  assign fl_set = fill_vpn[IDX_W-1:0];
  assign fl_tag = fill_vpn[VPN_W-1 -: TAG_W];

  // storage read data
  logic [WAYS-1:0]             ra_vld, ra_tpar, ra_dpar, fl_rd_valid;
  logic [WAYS-1:0][TAG_W-1:0]  ra_tag, fl_rd_tag;
  logic [WAYS-1:0][PFN_W-1:0]  ra_pfn;

  // named internal events
  logic [WAYS-1:0]  lk_good_vec, lk_perr_vec, fl_match_vec;
  logic [PFN_W-1:0] lk_hit_pfn;
  logic             lk_hit_now, lk_perr_now, lk_touch;
  logic             fl_match_any, fl_full, fill_we;
  way_t             lk_way, fl_way;
  plru_t            fl_state;
  logic [SETS*3-1:0] plru_flat;
  logic             wr_tpar, wr_dpar;

  xlat_tlb_store #(.SETS(SETS), .TAG_W(TAG_W), .PFN_W(PFN_W)) store_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .we      (fill_we),
    .wr_set  (fl_set),
    .wr_way  (fl_way),
    .wr_tag  (fl_tag),
    .wr_pfn  (fill_pfn),
    .wr_tpar (wr_tpar),
    .wr_dpar (wr_dpar),
    .ra_set  (lk_set),
    .ra_vld  (ra_vld),
    .ra_tag  (ra_tag),
    .ra_pfn  (ra_pfn),
    .ra_tpar (ra_tpar),
    .ra_dpar (ra_dpar),
    .rb_set  (fl_set),
    .rb_vld  (fl_rd_valid),
    .rb_tag  (fl_rd_tag)
  );

  xlat_tlb_match #(.TAG_W(TAG_W), .PFN_W(PFN_W)) match_i (
    .cmp_tag  (lk_tag),
    .vld      (ra_vld),
    .tag      (ra_tag),
    .pfn      (ra_pfn),
    .tpar     (ra_tpar),
    .dpar     (ra_dpar),
    .good_vec (lk_good_vec),
    .perr_vec (lk_perr_vec),
    .hit_pfn  (lk_hit_pfn)
  );

  assign lk_perr_now = lk_valid && (|lk_perr_vec);
  assign lk_hit_now  = lk_valid && (|lk_good_vec) && !(|lk_perr_vec);
  assign lk_touch    = lk_hit_now;
  assign lk_way      = onehot_idx(lk_good_vec);

  // fill placement: same tag, then first empty way, then tree victim
  for (genvar w = 0; w < WAYS; w++) begin : g_flm
    assign fl_match_vec[w] = fl_rd_valid[w] && (fl_rd_tag[w] == fl_tag);
  end
  assign fl_match_any = |fl_match_vec;
  assign fl_full      = &fl_rd_valid;
  assign fill_we      = fill_valid && !flush;

  always_comb begin
    if (fl_match_any)  fl_way = onehot_idx(fl_match_vec);
    else if (!fl_full) fl_way = first_clear(fl_rd_valid);
    else               fl_way = plru_victim(fl_state);
  end

  assign wr_tpar = even_par(32'(fl_tag))   ^ fill_par_flip[0];
  assign wr_dpar = even_par(32'(fill_pfn)) ^ fill_par_flip[1];

  xlat_tlb_plru #(.SETS(SETS)) plru_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .lk_touch  (lk_touch),
    .lk_set    (lk_set),
    .lk_way    (lk_way),
    .fl_touch  (fill_we),
    .fl_set    (fl_set),
    .fl_way    (fl_way),
    .fl_state  (fl_state),
    .all_state (plru_flat)
  );

  // registered result
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_hit   <= 1'b0;
      lk_perr  <= 1'b0;
      lk_paddr <= '0;
    end else begin
      lk_hit   <= lk_hit_now;
      lk_perr  <= lk_perr_now;
      lk_paddr <= lk_hit_now ? {lk_hit_pfn, lk_vaddr[PAGE_W-1:0]} : '0;
    end
  end

endmodule

// File: rtl/xlat_tlb_chk.sv
module xlat_tlb_chk #(
  parameter int unsigned VA_W   = 32,
  parameter int unsigned PA_W   = 32,
  parameter int unsigned PAGE_W = 12,
  parameter int unsigned SETS   = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              lk_valid,
  input logic [VA_W-1:0]   lk_vaddr,
  input logic              lk_hit,
  input logic [PA_W-1:0]   lk_paddr,
  input logic              lk_perr,
  input logic              lk_touch,
  input logic [3:0]        lk_good_vec,
  input logic              fill_we,
  input logic              fl_match_any,
  input logic [3:0]        fl_rd_valid,
  input logic [1:0]        fl_way,
  input logic [SETS*3-1:0] plru_flat
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> (!lk_hit && !lk_perr && lk_paddr == '0)); // R1

  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> (!lk_hit || lk_paddr[PAGE_W-1:0] == $past(lk_vaddr[PAGE_W-1:0]))); // R2

  AST_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_good_vec)); // R3

  AST_EMPTY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_we && !fl_match_any && !(&fl_rd_valid)) |-> !fl_rd_valid[fl_way]); // R4

  AST_PLRU_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fill_we && !lk_touch && !flush) |=> $stable(plru_flat)); // R6

  AST_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (plru_flat == '0)); // R7

  AST_PERR_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_perr)); // R9

endmodule

bind xlat_tlb xlat_tlb_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .PAGE_W(PAGE_W), .SETS(SETS)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .flush        (flush),
  .lk_valid     (lk_valid),
  .lk_vaddr     (lk_vaddr),
  .lk_hit       (lk_hit),
  .lk_paddr     (lk_paddr),
  .lk_perr      (lk_perr),
  .lk_touch     (lk_touch),
  .lk_good_vec  (lk_good_vec),
  .fill_we      (fill_we),
  .fl_match_any (fl_match_any),
  .fl_rd_valid  (fl_rd_valid),
  .fl_way       (fl_way),
  .plru_flat    (plru_flat)
);

// File: tb/xlat_tlb_tb_top.sv
module xlat_tlb_tb_top;

  localparam int NSETS = 16;
  localparam int NWAYS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic        lk_hit;
  logic [31:0] lk_paddr;
  logic        lk_perr;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [19:0] fill_pfn = '0;
  logic [1:0]  fill_par_flip = '0;

  always #10 clk = ~clk;  // 50 MHz

  xlat_tlb dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_hit(lk_hit), .lk_paddr(lk_paddr), .lk_perr(lk_perr),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .fill_par_flip(fill_par_flip)
  );

  int n_total = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 0;

  // reference model
  bit          m_vld [NSETS][NWAYS];
  logic [15:0] m_tag [NSETS][NWAYS];
  logic [19:0] m_pfn [NSETS][NWAYS];
  bit          m_bad [NSETS][NWAYS];
  int          m_lru [NSETS];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int lru_victim(input int st);
    if ((st % 2) == 1) return 2 + ((st / 4) % 2);
    return (st / 2) % 2;
  endfunction

  function automatic int lru_touch(input int st, input int w);
    int b0, b1, b2;
    b0 = st % 2; b1 = (st / 2) % 2; b2 = (st / 4) % 2;
    b0 = (w < 2) ? 1 : 0;
    if (w < 2) b1 = 1 - (w % 2);
    else       b2 = 1 - (w % 2);
    return b0 + 2 * b1 + 4 * b2;
  endfunction

  function automatic int find_way(input int s, input logic [15:0] t);
    for (int w = 0; w < NWAYS; w++) if (m_vld[s][w] && m_tag[s][w] == t) return w;
    return -1;
  endfunction

  function automatic int place_way(input int s, input logic [15:0] t);
    int w;
    w = find_way(s, t);
    if (w >= 0) return w;
    for (int i = 0; i < NWAYS; i++) if (!m_vld[s][i]) return i;
    return lru_victim(m_lru[s]);
  endfunction

  function automatic logic [33:0] expect_lookup(input logic [31:0] va);
    int s, w;
    s = int'(va[15:12]);
    w = find_way(s, va[31:16]);
    if (w < 0) return 34'd0;
    if (m_bad[s][w]) return {1'b0, 1'b1, 32'd0};
    return {1'b1, 1'b0, m_pfn[s][w], va[11:0]};
  endfunction

  task automatic model_touch_lookup(input logic [31:0] va);
    int s, w;
    s = int'(va[15:12]);
    w = find_way(s, va[31:16]);
    if (w >= 0 && !m_bad[s][w]) m_lru[s] = lru_touch(m_lru[s], w);
  endtask

  task automatic model_fill(input logic [19:0] vpn, input logic [19:0] pfn,
                            input logic [1:0] flip, input int w);
    int s;
    s = int'(vpn[3:0]);
    m_vld[s][w] = 1; m_tag[s][w] = vpn[19:4]; m_pfn[s][w] = pfn;
    m_bad[s][w] = (flip != 2'b00);
    m_lru[s] = lru_touch(m_lru[s], w);
  endtask

  task automatic model_clear();
    for (int s = 0; s < NSETS; s++) begin
      m_lru[s] = 0;
      for (int w = 0; w < NWAYS; w++) m_vld[s][w] = 0;
    end
  endtask

  task automatic do_lookup(input logic [31:0] va, input string req);
    logic [33:0] exp;
    exp = expect_lookup(va);
    @(negedge clk); lk_valid = 1'b1; lk_vaddr = va;
    @(negedge clk); lk_valid = 1'b0;
    check({lk_hit, lk_perr, lk_paddr} == exp, req, "lookup {hit,perr,paddr}",
          64'({lk_hit, lk_perr, lk_paddr}), 64'(exp));
    model_touch_lookup(va);
  endtask

  task automatic do_fill(input logic [19:0] vpn, input logic [19:0] pfn,
                         input logic [1:0] flip);
    int w;
    w = place_way(int'(vpn[3:0]), vpn[19:4]);
    @(negedge clk); fill_valid = 1'b1; fill_vpn = vpn; fill_pfn = pfn; fill_par_flip = flip;
    @(negedge clk); fill_valid = 1'b0; fill_par_flip = 2'b00;
    model_fill(vpn, pfn, flip, w);
  endtask

  function automatic logic [15:0] sw_tag(input int s, input int k);
    return 16'(k * 16'h1357 + s * 16'h0101 + 16'h0042);
  endfunction
  function automatic logic [19:0] sw_pfn(input int s, input int k);
    return 20'(s * 20'h0B01 + k * 20'h00777 + 20'h11);
  endfunction
  function automatic logic [31:0] sw_va(input int s, input int k);
    return {sw_tag(s, k), 4'(s), 12'((s * 37 + k * 211) % 4096)};
  endfunction

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      n_total++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    logic [33:0] exp_both;
    int fw;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state and idle outputs
    check(!lk_hit && !lk_perr && lk_paddr == 0, "R1", "reset outputs",
          64'({lk_hit, lk_perr, lk_paddr}), 64'd0);
    // R7: empty after reset
    do_lookup(32'hDEAD_5123, "R7");
    do_lookup(32'h0000_0000, "R7");

    // sweep every set: R2 R3 R4 R5 R6
    for (int s = 0; s < NSETS; s++) begin
      for (int k = 0; k < 4; k++) do_fill({sw_tag(s, k), 4'(s)}, sw_pfn(s, k), 2'b00);
      for (int k = 0; k < 4; k++) do_lookup(sw_va(s, k), "R2");
      // set-dependent touch pattern before eviction
      do_lookup(sw_va(s, s % 4), "R6");
      do_lookup(sw_va(s, (s / 4) % 4), "R6");
      do_fill({sw_tag(s, 4), 4'(s)}, sw_pfn(s, 4), 2'b00);
      if (s % 2 == 1) do_lookup(sw_va(s, (s + 1) % 4), "R6");
      do_fill({sw_tag(s, 5), 4'(s)}, sw_pfn(s, 5), 2'b00);
      for (int k = 0; k < 6; k++) do_lookup(sw_va(s, k), "R5");
      // a tag never filled misses, and a neighbouring set is not affected
      do_lookup({16'hFFFF, 4'(s), 12'h0AB}, "R3");
    end

    // R1: the cycle after a hit returns to quiet
    do_lookup(sw_va(0, 5), "R2");
    @(negedge clk);
    check(!lk_hit && lk_paddr == 0, "R1", "idle after hit",
          64'({lk_hit, lk_paddr}), 64'd0);

    // R4: refill of a present tag overwrites in place
    do_fill({sw_tag(2, 5), 4'd2}, 20'hABCDE, 2'b00);
    do_lookup(sw_va(2, 5), "R4");
    for (int k = 0; k < 6; k++) do_lookup(sw_va(2, k), "R4");

    // R8 R9: injected parity faults
    do_fill({sw_tag(5, 5), 4'd5}, 20'h12345, 2'b01);
    do_lookup(sw_va(5, 5), "R9");
    do_fill({sw_tag(6, 5), 4'd6}, 20'h54321, 2'b10);
    do_lookup(sw_va(6, 5), "R8");
    do_lookup(sw_va(6, 5), "R6");
    do_fill({sw_tag(6, 5), 4'd6}, 20'h54321, 2'b00);
    do_lookup(sw_va(6, 5), "R8");

    // R10: fill and lookup of the same page on one edge
    model_clear();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    do_fill(20'h1234_7, 20'h0F00D, 2'b00);
    exp_both = expect_lookup(32'h1235_7ABC);
    fw = place_way(7, 16'h1235);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = 32'h1235_7ABC;
    fill_valid = 1'b1; fill_vpn = 20'h1235_7; fill_pfn = 20'h0BEEF;
    @(negedge clk);
    lk_valid = 1'b0; fill_valid = 1'b0;
    check({lk_hit, lk_perr, lk_paddr} == exp_both, "R10", "same-edge lookup sees old",
          64'({lk_hit, lk_perr, lk_paddr}), 64'(exp_both));
    model_touch_lookup(32'h1235_7ABC);
    model_fill(20'h1235_7, 20'h0BEEF, 2'b00, fw);
    do_lookup(32'h1235_7ABC, "R10");

    // R6: hit and fill in one set, same edge; lookup update first
    do_fill(20'h1236_7, 20'h00003, 2'b00);
    do_fill(20'h1237_7, 20'h00004, 2'b00);
    exp_both = expect_lookup(32'h1234_7000);
    fw = place_way(7, 16'h1238);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = 32'h1234_7000;
    fill_valid = 1'b1; fill_vpn = 20'h1238_7; fill_pfn = 20'h00005;
    @(negedge clk);
    lk_valid = 1'b0; fill_valid = 1'b0;
    check({lk_hit, lk_perr, lk_paddr} == exp_both, "R6", "concurrent hit",
          64'({lk_hit, lk_perr, lk_paddr}), 64'(exp_both));
    model_touch_lookup(32'h1234_7000);
    model_fill(20'h1238_7, 20'h00005, 2'b00, fw);
    do_fill(20'h1239_7, 20'h00006, 2'b00);
    for (int t = 4; t < 10; t++) do_lookup({16'h1230 + 16'(t), 4'd7, 12'h010}, "R5");

    // R7: flush wins over a simultaneous fill
    @(negedge clk);
    flush = 1'b1; fill_valid = 1'b1; fill_vpn = 20'h4444_1; fill_pfn = 20'h00009;
    @(negedge clk);
    flush = 1'b0; fill_valid = 1'b0;
    model_clear();
    do_lookup(32'h4444_1000, "R7");
    do_lookup(32'h1239_7010, "R7");

    done = 1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule